// File: doc/BRIEF.md
# Four-Phase Asynchronous Bus Handshake

This block links a requesting controller and a responding controller over a bus with no shared clock. The requester accepts a command on its local side and drives address, direction and write data onto the bus. It then waits a fixed number of its own clock cycles so that the responder can decode the address, and only after that raises request. Request and acknowledge then move through a fully interlocked four-phase cycle: request up, acknowledge up, request down, acknowledge down.

Each controller runs on its own clock. The handshake wire coming into a controller passes through a synchroniser before its state machine sees it. The responder holds a small word-addressed store. It answers only addresses that fall inside its window. A write is stored before acknowledge rises, and read data is loaded onto the bus one cycle before acknowledge rises. The requester latches read data when it sees acknowledge. It holds the bus until acknowledge has fallen, then reports completion. If acknowledge does not arrive within a bounded wait, the requester withdraws request and reports a timeout.

Top module: `abus_link`

## Requirements
- R1: While reset is active and after it is released, bus request, bus acknowledge, cmd_busy, cmd_done and cmd_timeout are low, and cmd_rdata is zero.
- R2: From the clock edge that accepts a command until acknowledge has fallen again, the requester keeps bus address, direction and write data at the accepted command's values.
- R3: Request rises exactly DECODE_CYC requester clock edges after the edge that accepted the command, and the address does not change on the edge where request rises.
- R4: The responder raises acknowledge only while request is high, and on a write only after the data has been stored.
- R5: On a read, the responder's read data stays stable while acknowledge is high. The requester presents that data on cmd_rdata when cmd_done pulses.
- R6: The requester drops request only after it has seen acknowledge, unless a timeout occurs. The responder drops acknowledge only after request is low. Request never rises while acknowledge is high.
- R7: A command is accepted only while cmd_busy is low, and cmd_valid has no effect while cmd_busy is high. cmd_done pulses for one cycle once acknowledge has fallen, and cmd_busy falls on the same edge.
- R8: If acknowledge is not seen within TIMEOUT_CYC requester cycles after request rises, request drops and cmd_done pulses with cmd_timeout high. Request is never high for more than TIMEOUT_CYC consecutive cycles.
- R9: The responder answers only when the upper address bits equal SLAVE_BASE. With the defaults, the upper 4 bits of an 8-bit address must equal 3. The low log2(MEM_DEPTH) bits select the word. A write outside the window changes no stored word.
- R10: Every stored word is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester clock |
| rst_m_n | input | 1 | Requester reset, active low, asynchronous |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low, asynchronous |
| cmd_valid | input | 1 | Command strobe, accepted while cmd_busy is low |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| cmd_busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | DATA_W | Data from the last successful read |
| cmd_timeout | output | 1 | Valid with cmd_done: acknowledge never came |
| bus_req | output | 1 | Bus request wire (observable) |
| bus_ack | output | 1 | Bus acknowledge wire (observable) |
| bus_addr | output | ADDR_W | Bus address lines (observable) |

## Verification
The assertions assume that the two resets are released together. They also assume that each clock is fast enough for a synchronised request to reach the responder well inside the timeout window. Both are needed for the ordering properties to hold. The bench releases both resets in the same instant. It runs the requester at 4 ns and the responder at 6 ns, so a mapped access completes in far fewer than TIMEOUT_CYC requester cycles. The bench presents commands only on falling edges. Apart from one deliberate strobe sent while busy, it waits for cmd_busy to be low before each command.

// File: rtl/abus_pkg.sv
package abus_pkg;
   typedef enum logic [1:0] {
      M_IDLE,
      M_DECODE,
      M_REQ,
      M_RELEASE
   } mst_state_t;

   typedef enum logic [1:0] {
      S_IDLE,
      S_SERVE,
      S_ACK
   } slv_state_t;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("abus_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/abus_master.sv
module abus_master
   import abus_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int DECODE_CYC  = 3,
   parameter int TIMEOUT_CYC = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_busy,
   output logic              cmd_done,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic              cmd_timeout,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_req,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int DCW = $clog2(DECODE_CYC + 1);
   localparam int TW  = $clog2(TIMEOUT_CYC + 1);

   if (DECODE_CYC < 1) begin : g_bad_decode
      $error("abus_master: DECODE_CYC must be at least 1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("abus_master: TIMEOUT_CYC must be at least 2");
   end

   mst_state_t      state;
   logic [DCW-1:0]  dcnt;
   logic [TW-1:0]   tcnt;
   logic            ack_s;
   logic            to_flag;

   abus_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_ack),
      .q     (ack_s)
   );

   assign cmd_busy = (state != M_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= M_IDLE;
         dcnt        <= '0;
         tcnt        <= '0;
         to_flag     <= 1'b0;
         bus_addr    <= '0;
         bus_write   <= 1'b0;
         bus_wdata   <= '0;
         bus_req     <= 1'b0;
         cmd_done    <= 1'b0;
         cmd_timeout <= 1'b0;
         cmd_rdata   <= '0;
      end else begin
         cmd_done    <= 1'b0;
         cmd_timeout <= 1'b0;
         case (state)
            M_IDLE: begin
               if (cmd_valid) begin
                  bus_addr  <= cmd_addr;
                  bus_write <= cmd_write;
                  bus_wdata <= cmd_wdata;
                  dcnt      <= DCW'(DECODE_CYC - 1);
                  state     <= M_DECODE;
               end
            end
            M_DECODE: begin
               if (dcnt == '0) begin
                  bus_req <= 1'b1;
                  tcnt    <= '0;
                  state   <= M_REQ;
               end else begin
                  dcnt <= dcnt - 1'b1;
               end
            end
            M_REQ: begin
               if (ack_s) begin
                  bus_req <= 1'b0;
                  if (!bus_write) cmd_rdata <= bus_rdata;
                  state <= M_RELEASE;
               end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
                  bus_req <= 1'b0;
                  to_flag <= 1'b1;
                  state   <= M_RELEASE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            M_RELEASE: begin
               if (!ack_s) begin
                  cmd_done    <= 1'b1;
                  cmd_timeout <= to_flag;
                  to_flag     <= 1'b0;
                  state       <= M_IDLE;
               end
            end
            default: state <= M_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/abus_slave.sv
module abus_slave
   import abus_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int MEM_DEPTH   = 16,
   parameter int SLAVE_BASE  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_write,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_req,
   output logic              bus_ack,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int IW = $clog2(MEM_DEPTH);
   localparam int BW = ADDR_W - IW;

   if ((1 << IW) != MEM_DEPTH) begin : g_bad_depth
      $error("abus_slave: MEM_DEPTH must be a power of two");
   end
   if (BW < 1) begin : g_bad_width
      $error("abus_slave: ADDR_W must exceed log2(MEM_DEPTH)");
   end
   if (SLAVE_BASE >= (1 << BW)) begin : g_bad_base
      $error("abus_slave: SLAVE_BASE does not fit the upper address bits");
   end

   slv_state_t        state;
   logic              req_s;
   logic              sel;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] mem [MEM_DEPTH];

   abus_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_req),
      .q     (req_s)
   );

   assign sel = (bus_addr[ADDR_W-1:IW] == BW'(SLAVE_BASE));
   assign idx = bus_addr[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_s && sel) begin
                  if (bus_write) mem[idx]  <= bus_wdata;
                  else           bus_rdata <= mem[idx];
                  state <= S_SERVE;
               end
            end
            S_SERVE: begin
               bus_ack <= 1'b1;
               state   <= S_ACK;
            end
            S_ACK: begin
               if (!req_s) begin
                  bus_ack <= 1'b0;
                  state   <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/abus_link.sv
module abus_link #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int MEM_DEPTH   = 16,
   parameter int SLAVE_BASE  = 3,
   parameter int DECODE_CYC  = 3,
   parameter int TIMEOUT_CYC = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_m,
   input  logic              rst_m_n,
   input  logic              clk_s,
   input  logic              rst_s_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_busy,
   output logic              cmd_done,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic              cmd_timeout,
   output logic              bus_req,
   output logic              bus_ack,
   output logic [ADDR_W-1:0] bus_addr
);
   logic              bus_write;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;

   abus_master #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .DECODE_CYC  (DECODE_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_master (
      .clk         (clk_m),
      .rst_n       (rst_m_n),
      .cmd_valid   (cmd_valid),
      .cmd_write   (cmd_write),
      .cmd_addr    (cmd_addr),
      .cmd_wdata   (cmd_wdata),
      .cmd_busy    (cmd_busy),
      .cmd_done    (cmd_done),
      .cmd_rdata   (cmd_rdata),
      .cmd_timeout (cmd_timeout),
      .bus_addr    (bus_addr),
      .bus_write   (bus_write),
      .bus_wdata   (bus_wdata),
      .bus_req     (bus_req),
      .bus_ack     (bus_ack),
      .bus_rdata   (bus_rdata)
   );

   abus_slave #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .MEM_DEPTH   (MEM_DEPTH),
      .SLAVE_BASE  (SLAVE_BASE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_slave (
      .clk       (clk_s),
      .rst_n     (rst_s_n),
      .bus_addr  (bus_addr),
      .bus_write (bus_write),
      .bus_wdata (bus_wdata),
      .bus_req   (bus_req),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );
endmodule

// File: rtl/abus_link_chk.sv
module abus_link_chk #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int TIMEOUT_CYC = 64
) (
   input logic              clk_m,
   input logic              rst_m_n,
   input logic              clk_s,
   input logic              rst_s_n,
   input logic              bus_req,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_write,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cmd_done,
   input logic              cmd_timeout
);
   localparam int RW = $clog2(TIMEOUT_CYC + 2);

   logic [RW-1:0] req_run;

   always_ff @(posedge clk_m or negedge rst_m_n) begin
      if (!rst_m_n)     req_run <= '0;
      else if (bus_req) req_run <= req_run + 1'b1;
      else              req_run <= '0;
   end

   assert_addr_settled_R3: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      $rose(bus_req) |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

   assert_bus_hold_R2: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      ((bus_req || bus_ack) && $past(bus_req || bus_ack))
         |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

   assert_req_needs_ack_low_R6: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      $rose(bus_req) |-> !bus_ack);

   assert_ack_under_req_R4: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      $rose(bus_ack) |-> bus_req);

   assert_ack_drop_after_req_R6: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      $fell(bus_ack) |-> !bus_req);

   assert_rdata_stable_R5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      (bus_ack && !bus_write) |-> $stable(bus_rdata));

   assert_req_window_R8: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      req_run <= RW'(TIMEOUT_CYC));

   assert_timeout_with_done_R8: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      cmd_timeout |-> cmd_done);

   assert_done_bus_quiet_R7: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      cmd_done |-> (!bus_req && !bus_ack));
endmodule

bind abus_link abus_link_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .TIMEOUT_CYC (TIMEOUT_CYC)
) i_chk (
   .clk_m       (clk_m),
   .rst_m_n     (rst_m_n),
   .clk_s       (clk_s),
   .rst_s_n     (rst_s_n),
   .bus_req     (bus_req),
   .bus_ack     (bus_ack),
   .bus_addr    (bus_addr),
   .bus_write   (bus_write),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .cmd_done    (cmd_done),
   .cmd_timeout (cmd_timeout)
);

// File: tb/test_abus_link.sv
module test_abus_link;
   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int DEC = 3;
   localparam int NV  = 8;

   // {write, addr, wdata, expected rdata, expected timeout}
   localparam logic [41:0] VEC [NV] = '{
      {1'b1, 8'h30, 16'hA5A5, 16'h0000, 1'b0},
      {1'b1, 8'h3F, 16'h1234, 16'h0000, 1'b0},
      {1'b0, 8'h30, 16'h0000, 16'hA5A5, 1'b0},
      {1'b0, 8'h3F, 16'h0000, 16'h1234, 1'b0},
      {1'b1, 8'h55, 16'hDEAD, 16'h0000, 1'b1},
      {1'b0, 8'h55, 16'h0000, 16'h0000, 1'b1},
      {1'b1, 8'h35, 16'h0F0F, 16'h0000, 1'b0},
      {1'b0, 8'h35, 16'h0000, 16'h0F0F, 1'b0}
   };

   logic          clk_m = 1'b0;
   logic          clk_s = 1'b0;
   logic          rst_m_n = 1'b0;
   logic          rst_s_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          cmd_busy, cmd_done, cmd_timeout;
   logic [DW-1:0] cmd_rdata;
   logic          bus_req, bus_ack;
   logic [AW-1:0] bus_addr;

   int checks = 0;
   int failures = 0;

   always #2 clk_m = ~clk_m;
   always #3 clk_s = ~clk_s;

   abus_link #(.DECODE_CYC(DEC)) i_abus_link (
      .clk_m       (clk_m),
      .rst_m_n     (rst_m_n),
      .clk_s       (clk_s),
      .rst_s_n     (rst_s_n),
      .cmd_valid   (cmd_valid),
      .cmd_write   (cmd_write),
      .cmd_addr    (cmd_addr),
      .cmd_wdata   (cmd_wdata),
      .cmd_busy    (cmd_busy),
      .cmd_done    (cmd_done),
      .cmd_rdata   (cmd_rdata),
      .cmd_timeout (cmd_timeout),
      .bus_req     (bus_req),
      .bus_ack     (bus_ack),
      .bus_addr    (bus_addr)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // Issues one command and watches the bus until cmd_done.
   task automatic run_cmd(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit poke_busy,
                          output logic [DW-1:0] rd, output logic to, output int dly,
                          output bit hold_ok, output bit early_ack, output bit drop_no_ack);
      bit prev_req = 1'b0;
      bit seen_ack = 1'b0;
      int cnt = 0;
      @(negedge clk_m);
      while (cmd_busy) @(negedge clk_m);
      cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
      @(negedge clk_m);
      cmd_valid = 1'b0;
      dly = -1; hold_ok = 1'b1; early_ack = 1'b0; drop_no_ack = 1'b0;
      while (!cmd_done) begin
         if (bus_addr != a) hold_ok = 1'b0;
         if (bus_req && dly < 0) dly = cnt;
         if (bus_ack && dly < 0) early_ack = 1'b1;
         if (bus_ack) seen_ack = 1'b1;
         if (prev_req && !bus_req && !seen_ack) drop_no_ack = 1'b1;
         prev_req = bus_req;
         if (poke_busy && cnt == 2) begin
            cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h32; cmd_wdata = 16'hBEEF;
         end else begin
            cmd_valid = 1'b0;
         end
         cnt++;
         @(negedge clk_m);
      end
      cmd_valid = 1'b0;
      rd = cmd_rdata;
      to = cmd_timeout;
   endtask

   initial begin
      #40000;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      logic to;
      int dly;
      bit hold_ok, early_ack, drop_no_ack;

      repeat (4) @(negedge clk_m);
      // R1: reset state while reset is held
      check(!bus_req && !bus_ack && !cmd_busy && !cmd_done && !cmd_timeout && cmd_rdata == '0,
            "R1", "outputs during reset",
            {bus_req, bus_ack, cmd_busy, cmd_done, cmd_timeout, 11'd0, cmd_rdata}, 32'h0);
      rst_m_n = 1'b1;
      rst_s_n = 1'b1;
      repeat (3) @(negedge clk_m);
      check(!bus_req && !bus_ack && !cmd_busy && !cmd_done, "R1", "outputs after release",
            {bus_req, bus_ack, cmd_busy, cmd_done}, 32'h0);

      // R10: stored words start at zero
      run_cmd(1'b0, 8'h3A, 16'h0, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(rd == 16'h0 && !to, "R10", "read of fresh word", rd, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic        vw;
         logic [7:0]  va;
         logic [15:0] vd, ve;
         logic        vt;
         {vw, va, vd, ve, vt} = VEC[i];
         run_cmd(vw, va, vd, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
         check(to == vt, "R8", $sformatf("vec %0d timeout flag", i), to, vt);
         check(dly == DEC, "R3", $sformatf("vec %0d request delay", i), dly, DEC);
         check(hold_ok, "R2", $sformatf("vec %0d address held", i), hold_ok, 1);
         check(!early_ack, "R4", $sformatf("vec %0d ack before req", i), early_ack, 0);
         check(drop_no_ack == vt, "R6", $sformatf("vec %0d req drop order", i), drop_no_ack, vt);
         if (!vw && !vt)
            check(rd == ve, "R5", $sformatf("vec %0d read data", i), rd, ve);
      end

      // R7: a strobe while busy must not start a second access
      run_cmd(1'b1, 8'h31, 16'h7777, 1'b1, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(hold_ok, "R7", "address kept despite strobe while busy", hold_ok, 1);
      repeat (4) @(negedge clk_m);
      check(!cmd_busy && !bus_req, "R7", "idle after done", {cmd_busy, bus_req}, 0);
      run_cmd(1'b0, 8'h32, 16'h0, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(rd == 16'h0, "R7", "ignored write left word unchanged", rd, 0);
      run_cmd(1'b0, 8'h31, 16'h0, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(rd == 16'h7777, "R5", "read back accepted write", rd, 16'h7777);

      // R9: write outside the window must not alias onto index 5
      run_cmd(1'b1, 8'h05, 16'h1111, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(to == 1'b1, "R9", "unmapped write times out", to, 1);
      run_cmd(1'b0, 8'h35, 16'h0, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(rd == 16'h0F0F && !to, "R9", "word 5 unchanged", rd, 16'h0F0F);

      // R8: cmd_rdata unchanged by a timed-out read
      run_cmd(1'b0, 8'hF0, 16'h0, 1'b0, rd, to, dly, hold_ok, early_ack, drop_no_ack);
      check(to && rd == 16'h0F0F, "R8", "timed-out read keeps last data", rd, 16'h0F0F);

      finish_run();
   end
endmodule